// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block connects two parallel buses, A and B, each `WIDTH` bits wide. Each transfer direction has its own bank of storage flops. A bus can therefore be driven either with the live value of the other bus or with a value captured earlier. An active-low output enable and a direction input decide which side drives, if either does. Each direction has its own select input, which picks live or stored data for that direction.

The pads are split into input, output and output-enable signals for each side. Capture requests arrive as level inputs. The block samples them with the system clock and loads a bank on the rising transition of its request. Capture ignores the enable, direction and select inputs.

Top module: `reg_bus_xcvr`

## Requirements
- R1: After reset both storage banks hold zero. With a select high, its driven output reads 0.
- R2: The A-bank loads `a_i` at the first clock edge where `cap_a_i` is sampled high after being sampled low.
- R3: The B-bank loads `b_i` at the first clock edge where `cap_b_i` is sampled high after being sampled low.
- R4: Capture takes place whatever the values of `oe_n_i`, `dir_i`, `sel_ab_i` and `sel_ba_i`. Both banks may load on the same edge.
- R5: While `sel_ab_i` is 0, `b_o` equals `a_i` in the same cycle.
- R6: While `sel_ab_i` is 1, `b_o` equals the A-bank contents.
- R7: While `sel_ba_i` is 0, `a_o` equals `b_i`. While it is 1, `a_o` equals the B-bank contents.
- R8: While `oe_n_i` is 1, `a_oe_o` and `b_oe_o` are both 0.
- R9: While `oe_n_i` is 0, `dir_i` = 1 gives `b_oe_o` = 1 and `a_oe_o` = 0. `dir_i` = 0 gives `a_oe_o` = 1 and `b_oe_o` = 0.
- R10: When a select input toggles, the driven output goes directly to the value for the new selection. No third value appears in between.
- R11: Holding a capture request high loads the bank only once. A later change on the bus leaves the stored value as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dir_i | input | 1 | 1: drive B from A side, 0: drive A from B side |
| sel_ab_i | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A-side source: 0 live B, 1 stored B |
| cap_a_i | input | 1 | A-bank capture request (rising transition) |
| cap_b_i | input | 1 | B-bank capture request (rising transition) |
| a_i | input | WIDTH | Bus A pad input |
| a_o | output | WIDTH | Bus A pad output |
| a_oe_o | output | 1 | Bus A output enable |
| b_i | input | WIDTH | Bus B pad input |
| b_o | output | WIDTH | Bus B pad output |
| b_oe_o | output | 1 | Bus B output enable |

## Verification
The bench builds the block with the default `WIDTH` of 8. At that width all 256 codes can be swept on both the live and the stored paths. Each stored sweep step also visits one of the 16 combinations of enable, direction and the two selects. This shows that capture ignores the controls and that the enable decoding is complete. Held capture requests, simultaneous loads and select toggles are each checked at chosen codes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  function automatic drive_e drive_decode(input logic oe_n, input logic dir);
    if (oe_n) return DRV_NONE;
    return dir ? DRV_B : DRV_A;
  endfunction
endpackage

// File: rtl/xcvr_rise.sv
module xcvr_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic stb_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;

  assign stb_o = level_i & ~prev_q;

  // R11
  single_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic             sel_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] store_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)     store_q[g] <= 1'b0;
      else if (load_i) store_q[g] <= d_i[g];

    // one AND-OR mux per bit; no decoded intermediate
    assign y_o[g] = (sel_i & store_q[g]) | (~sel_i & live_i[g]);
  end

  // R2 R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> store_q == $past(d_i));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(store_q));
  // R6 R7
  stored_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> y_o == store_q);
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oe_n_i,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             cap_a_i,
  input  logic             cap_b_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  logic   stb_a, stb_b;
  drive_e drv;

  xcvr_rise i_rise_a (.clk_i, .rst_ni, .level_i(cap_a_i), .stb_o(stb_a));
  xcvr_rise i_rise_b (.clk_i, .rst_ni, .level_i(cap_b_i), .stb_o(stb_b));

  xcvr_lane #(.WIDTH(WIDTH)) i_lane_ab (
    .clk_i, .rst_ni, .load_i(stb_a), .d_i(a_i), .live_i(a_i),
    .sel_i(sel_ab_i), .y_o(b_o)
  );
  xcvr_lane #(.WIDTH(WIDTH)) i_lane_ba (
    .clk_i, .rst_ni, .load_i(stb_b), .d_i(b_i), .live_i(b_i),
    .sel_i(sel_ba_i), .y_o(a_o)
  );

  assign drv    = drive_decode(oe_n_i, dir_i);
  assign a_oe_o = (drv == DRV_A);
  assign b_oe_o = (drv == DRV_B);

  // R8
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !a_oe_o && !b_oe_o);
  // R9
  one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_i |-> $onehot({a_oe_o, b_oe_o}) && (b_oe_o == dir_i));
  // R5
  live_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ab_i |-> b_o == a_i);
  // R7
  live_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ba_i |-> a_o == b_i);
endmodule

// File: tb/test_reg_bus_xcvr.sv
module test_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0, cap_a = 0, cap_b = 0;
  logic [W-1:0] a_in = 0, b_in = 0, a_out, b_out;
  logic a_oe, b_oe;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) i_reg_bus_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .oe_n_i(oe_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_a_i(cap_a), .cap_b_i(cap_b),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic capture(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic da, input logic db);
    @(negedge clk);
    a_in = av; b_in = bv; cap_a = da; cap_b = db;
    @(negedge clk);
    cap_a = 0; cap_b = 0;
  endtask

  logic [W-1:0] sa, sb;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    sel_ab = 1; sel_ba = 1; a_in = 8'h5a; b_in = 8'ha5; #1;
    chk("R1 A-bank", b_out, 0);
    chk("R1 B-bank", a_out, 0);

    // R5 R7 live sweep
    sel_ab = 0; sel_ba = 0;
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v); b_in = ~W'(v); #1;
      chk("R5 live A->B", b_out, W'(v));
      chk("R7 live B->A", a_out, ~W'(v));
    end

    // R8 R9 decode over all controls
    for (int c = 0; c < 4; c++) begin
      oe_n = c[1]; dir = c[0]; #1;
      chk("R8/R9 a_oe", W'(a_oe), W'(!c[1] && !c[0]));
      chk("R8/R9 b_oe", W'(b_oe), W'(!c[1] && c[0]));
    end

    // R2 R3 R4 R6 R7 stored sweep, controls vary during capture
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      oe_n = v[0]; dir = v[1]; sel_ab = v[2]; sel_ba = v[3];
      capture(W'(v), W'(v * 37 + 11), 1, 1);
      sel_ab = 1; sel_ba = 1;
      a_in = ~W'(v); b_in = W'(v + 3); #1;
      chk("R2/R4/R6 stored A", b_out, W'(v));
      chk("R3/R4/R7 stored B", a_out, W'(v * 37 + 11));
    end

    // R2 R3 separate capture: only one bank loads
    capture(8'h11, 8'h22, 1, 1);
    capture(8'h33, 8'h44, 1, 0);
    #1;
    chk("R2 only A", b_out, 8'h33);
    chk("R3 B kept", a_out, 8'h22);
    capture(8'h55, 8'h66, 0, 1);
    #1;
    chk("R2 A kept", b_out, 8'h33);
    chk("R3 only B", a_out, 8'h66);

    // R11 held request captures once
    @(negedge clk);
    a_in = 8'hc3; b_in = 8'h3c; cap_a = 1; cap_b = 1;
    @(negedge clk);
    a_in = 8'h0f; b_in = 8'hf0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 A held", b_out, 8'hc3);
    chk("R11 B held", a_out, 8'h3c);
    cap_a = 0; cap_b = 0;

    // R10 select toggles land directly on new value
    @(negedge clk);
    sa = 8'hc3; sb = 8'h3c;
    a_in = 8'h99; b_in = 8'h66;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      sel_ab = ~sel_ab; sel_ba = ~sel_ba;
      #1;
      chk("R10 toggle b_o", b_out, sel_ab ? sa : a_in);
      chk("R10 toggle a_o", a_out, sel_ba ? sb : b_in);
      @(posedge clk); #1;
      chk("R10 settled b_o", b_out, sel_ab ? sa : a_in);
    end

    // R1 reset again clears banks
    @(negedge clk);
    rst_n = 0; #1;
    rst_n = 1; sel_ab = 1; sel_ba = 1; #1;
    chk("R1 reclear A", b_out, 0);
    chk("R1 reclear B", a_out, 0);

    finish_run();
  end
endmodule